// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external asynchronous 256K x 8 static RAM. The host offers one word at a time with a request/ready handshake: an 18-bit address, a direction bit and, for writes, a data byte. The controller turns each accepted request into a pin-level sequence of chip enable, output enable and write enable. Read data comes back to the host with a one-cycle valid pulse.

Every timing minimum of the memory is given in nanoseconds for one speed grade (55, 70 or 85 ns). Each one is rounded up to a whole number of clock periods when the block is built. Address, write data and all strobes leave the block from flops, so no decode glitch reaches the memory. The controller follows the turnaround rules of an asynchronous part. The address moves only while the strobes are idle. The two enables that open the data pins are never low together. The shared data bus is not driven again until the memory has had time to release it after a read.

Top module: `asram_ctl`

## Requirements
- R1: After reset, and whenever no access is in progress, hostReady is 1, memCe1N, memOeN and memWeN are 1 and memDqOe is 0. memCe2 is 1 at all times.
- R2: A read accepted on a clock edge (hostReq=1, hostWrite=0 while hostReady=1) is followed by one cycle with the new address on memAddr and all strobes high. Then memCe1N and memOeN are low, with memWeN high, for RD = ceil(max(grade, 40 ns) / clock period) cycles. That is 3 cycles for the 55 ns grade at a 20 ns clock.
- R3: The byte on memDqIn is sampled at the edge that ends the low window of memOeN. In the next cycle the strobes are high, hostRvalid is 1 for exactly that one cycle, and hostRdata holds the sampled byte.
- R4: An accepted write (hostWrite=1) drives the latched byte on memDqOut with memDqOe=1 for one cycle with all strobes high. Then memCe1N and memWeN are low, with memOeN high, for WP cycles. WP is the largest of the write pulse, address-to-end and data-setup minimums (40/40/25, 50/60/30 and 60/70/35 ns for the three grades), rounded up. It is 2 cycles for the 55 ns grade at a 20 ns clock.
- R5: After the write strobe ends, the data stays driven with all strobes high for max(1, ceil(grade / period) - 1 - WP) cycles. The bus is then released and the block returns to idle.
- R6: memAddr changes only on the edge that accepts a request, so it is stable whenever memCe1N is low together with memWeN or memOeN.
- R7: memDqOe is never 1 while memOeN is 0. memDqOe rises no earlier than TURN = ceil(tOHZ / period) cycles after memOeN last rose, where tOHZ is 20/25/30 ns by grade. Extra wait cycles are inserted when needed.
- R8: hostReady is 1 only in idle. The address, data and direction are latched at acceptance, so changes on hostAddr, hostWdata or hostWrite during an access have no effect on the memory pins.
- R9: memOeN and memWeN are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | Access request |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 18 | Word address |
| hostWdata | input | 8 | Write byte |
| hostReady | output | 1 | Controller idle, request accepted this edge |
| hostRdata | output | 8 | Read byte |
| hostRvalid | output | 1 | One-cycle read data valid |
| memAddr | output | 18 | Memory address pins |
| memCe1N | output | 1 | Chip enable, active low |
| memCe2 | output | 1 | Second chip enable, held high |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memDqOut | output | 8 | Data driven toward the memory |
| memDqOe | output | 1 | Enable for the data drivers |
| memDqIn | input | 8 | Data returned from the memory |

## Verification
The bound checker checks the pin-level safety rules on every cycle. It checks that the address holds while a strobe pair is active, that output enable and write enable are never low together, and that the data drivers stay off while output enable is low and for the turnaround window after it rises. It also checks the minimum write pulse width, that ready appears only with all strobes idle, and that the read-valid pulse lasts a single cycle. The exact order of cycles can only be shown by the bench's scenarios, which compare every pin against a cycle-by-cycle model. Those scenarios cover the setup, strobe, capture and recovery phases, a write that follows a read directly, the returned data, and the fact that host inputs changed in the middle of an access are ignored.

// File: rtl/asram_ctl_pkg.sv
package asram_ctl_pkg;

  typedef enum logic [2:0] {
    IDLE, RD_SETUP, RD_WAIT, RD_CAPTURE, BUS_TURN, WR_SETUP, WR_PULSE, WR_RECOVER
  } state_t;

  // strobes from control to datapath; ce/oe/we/drive/rvalid are registered,
  // load/capture are single-edge enables
  typedef struct packed {
    logic ce;
    logic oe;
    logic we;
    logic drive;
    logic rvalid;
    logic load;
    logic capture;
  } strobe_t;

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int ceilDiv(input int n, input int d);
    return (n + d - 1) / d;
  endfunction

  function automatic int ohzNs(input int g);
    return (g <= 55) ? 20 : (g <= 70) ? 25 : 30;
  endfunction

  function automatic int wpNs(input int g);
    return (g <= 55) ? 40 : (g <= 70) ? 50 : 60;
  endfunction

  function automatic int awNs(input int g);
    return (g <= 55) ? 40 : (g <= 70) ? 60 : 70;
  endfunction

  function automatic int dwNs(input int g);
    return (g <= 55) ? 25 : (g <= 70) ? 30 : 35;
  endfunction

  function automatic int rdCycles(input int g, input int c);
    return maxInt(1, ceilDiv(maxInt(g, 40), c));
  endfunction

  function automatic int wpCycles(input int g, input int c);
    return maxInt(1, ceilDiv(maxInt(wpNs(g), maxInt(awNs(g), dwNs(g))), c));
  endfunction

  function automatic int recCycles(input int g, input int c);
    return maxInt(1, ceilDiv(g, c) - 1 - wpCycles(g, c));
  endfunction

  function automatic int turnCycles(input int g, input int c);
    return maxInt(1, ceilDiv(ohzNs(g), c));
  endfunction

endpackage

// File: rtl/asram_ctl_fsm.sv
module asram_ctl_fsm
  import asram_ctl_pkg::*;
#(
  parameter int SPEED_NS = 55,
  parameter int CLK_NS   = 20
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    hostReq,
  input  logic    hostWrite,
  output logic    hostReady,
  output strobe_t ctl
);

  localparam int RD_CYC   = rdCycles(SPEED_NS, CLK_NS);
  localparam int WP_CYC   = wpCycles(SPEED_NS, CLK_NS);
  localparam int REC_CYC  = recCycles(SPEED_NS, CLK_NS);
  localparam int TURN_CYC = turnCycles(SPEED_NS, CLK_NS);
  localparam int CNT_MAX  = maxInt(maxInt(RD_CYC, WP_CYC), maxInt(REC_CYC, TURN_CYC));
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  state_t st, stNext;
  logic [CNT_W-1:0] waitCnt, turnLeft;
  strobe_t pinsQ, pinsNext;

  wire lastCycle = (waitCnt == CNT_W'(1));
  wire turnBusy  = (turnLeft > CNT_W'(1));

  always_comb begin
    stNext = st;
    unique case (st)
      IDLE:       if (hostReq) stNext = hostWrite ? (turnBusy ? BUS_TURN : WR_SETUP) : RD_SETUP;
      RD_SETUP:   stNext = RD_WAIT;
      RD_WAIT:    if (lastCycle) stNext = RD_CAPTURE;
      RD_CAPTURE: stNext = IDLE;
      BUS_TURN:   if (!turnBusy) stNext = WR_SETUP;
      WR_SETUP:   stNext = WR_PULSE;
      WR_PULSE:   if (lastCycle) stNext = WR_RECOVER;
      WR_RECOVER: if (lastCycle) stNext = IDLE;
      default:    stNext = IDLE;
    endcase
  end

  // pin levels for the state being entered, so pins come straight from flops
  always_comb begin
    pinsNext = '0;
    unique case (stNext)
      RD_WAIT:    begin pinsNext.ce = 1'b1; pinsNext.oe = 1'b1; end
      RD_CAPTURE: pinsNext.rvalid = 1'b1;
      WR_SETUP:   pinsNext.drive = 1'b1;
      WR_PULSE:   begin pinsNext.ce = 1'b1; pinsNext.we = 1'b1; pinsNext.drive = 1'b1; end
      WR_RECOVER: pinsNext.drive = 1'b1;
      default:    pinsNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= IDLE;
      waitCnt  <= '0;
      turnLeft <= '0;
      pinsQ    <= '0;
    end else begin
      st    <= stNext;
      pinsQ <= pinsNext;
      if (stNext != st) begin
        unique case (stNext)
          RD_WAIT:    waitCnt <= CNT_W'(RD_CYC);
          WR_PULSE:   waitCnt <= CNT_W'(WP_CYC);
          WR_RECOVER: waitCnt <= CNT_W'(REC_CYC);
          default:    waitCnt <= '0;
        endcase
      end else if (waitCnt != '0) begin
        waitCnt <= waitCnt - CNT_W'(1);
      end
      if (stNext == RD_CAPTURE) turnLeft <= CNT_W'(TURN_CYC);
      else if (turnLeft != '0)  turnLeft <= turnLeft - CNT_W'(1);
    end
  end

  assign hostReady = (st == IDLE);

  always_comb begin
    ctl         = pinsQ;
    ctl.load    = (st == IDLE) && hostReq;
    ctl.capture = (st == RD_WAIT) && lastCycle;
  end

endmodule

// File: rtl/asram_ctl_dp.sv
module asram_ctl_dp
  import asram_ctl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           ctl,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostRvalid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1N,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (ctl.load) begin
        addrQ  <= hostAddr;
        wdataQ <= hostWdata;
      end
      if (ctl.capture) rdataQ <= memDqIn;
    end
  end

  assign memAddr    = addrQ;
  assign memDqOut   = wdataQ;
  assign memDqOe    = ctl.drive;
  assign memCe1N    = ~ctl.ce;
  assign memOeN     = ~ctl.oe;
  assign memWeN     = ~ctl.we;
  assign hostRdata  = rdataQ;
  assign hostRvalid = ctl.rvalid;

endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
  import asram_ctl_pkg::*;
#(
  parameter int SPEED_NS = 55,
  parameter int CLK_NS   = 20,
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic              hostReady,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostRvalid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  strobe_t ctl;

  asram_ctl_fsm #(.SPEED_NS(SPEED_NS), .CLK_NS(CLK_NS)) i_fsm (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostReady(hostReady), .ctl(ctl)
  );

  asram_ctl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .hostRvalid(hostRvalid), .memAddr(memAddr),
    .memCe1N(memCe1N), .memOeN(memOeN), .memWeN(memWeN), .memDqOut(memDqOut),
    .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  assign memCe2 = 1'b1;

endmodule

// File: rtl/asram_ctl_chk.sv
module asram_ctl_chk
  import asram_ctl_pkg::*;
#(
  parameter int SPEED_NS = 55,
  parameter int CLK_NS   = 20,
  parameter int ADDR_W   = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostReady,
  input logic              hostRvalid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCe1N,
  input logic              memCe2,
  input logic              memOeN,
  input logic              memWeN,
  input logic              memDqOe
);

  localparam int TURN_CYC = turnCycles(SPEED_NS, CLK_NS);
  localparam int WP_CYC   = wpCycles(SPEED_NS, CLK_NS);
  localparam int QW       = $clog2(maxInt(TURN_CYC, WP_CYC) + 2);
  localparam logic [QW-1:0] QMAX = '1;

  logic [QW-1:0] oeQuiet, weLow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oeQuiet <= QMAX;
      weLow   <= '0;
    end else begin
      if (!memOeN)            oeQuiet <= '0;
      else if (oeQuiet != QMAX) oeQuiet <= oeQuiet + QW'(1);
      if (memWeN)             weLow <= '0;
      else if (weLow != QMAX) weLow <= weLow + QW'(1);
    end
  end

  p_ce2_high_r1: assert property (@(posedge clk) disable iff (!rstN) memCe2);

  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |-> (memCe1N && memOeN && memWeN && !memDqOe));

  p_rvalid_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    hostRvalid |=> !hostRvalid);

  p_we_width_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weLow >= QW'(WP_CYC)));

  p_addr_hold_wr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!memCe1N && !memWeN) |=> ((memCe1N || memWeN) || $stable(memAddr)));

  p_addr_hold_rd_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!memCe1N && !memOeN) |=> ((memCe1N || memOeN) || $stable(memAddr)));

  p_no_fight_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && memDqOe));

  p_turnaround_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memDqOe) |-> (oeQuiet >= QW'(TURN_CYC)));

  p_oe_we_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && !memWeN));

endmodule

bind asram_ctl asram_ctl_chk #(.SPEED_NS(SPEED_NS), .CLK_NS(CLK_NS), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .hostReady(hostReady), .hostRvalid(hostRvalid),
  .memAddr(memAddr), .memCe1N(memCe1N), .memCe2(memCe2), .memOeN(memOeN),
  .memWeN(memWeN), .memDqOe(memDqOe)
);

// File: tb/test_asram_ctl.sv
`timescale 1ns/1ps
module test_asram_ctl;

  localparam int PER  = 20;
  localparam int RD   = (55 + PER - 1) / PER;          // max(55,40) ns
  localparam int WP   = (40 + PER - 1) / PER;          // max(40,40,25) ns
  localparam int MINC = (55 + PER - 1) / PER;
  localparam int REC  = (MINC - 1 - WP) > 1 ? (MINC - 1 - WP) : 1;
  localparam int TURN = (20 + PER - 1) / PER;

  logic clk = 1'b0, rstN = 1'b0;
  logic hostReq = 1'b0, hostWrite = 1'b0;
  logic [17:0] hostAddr = '0;
  logic [7:0]  hostWdata = '0;
  logic hostReady, hostRvalid, memCe1N, memCe2, memOeN, memWeN, memDqOe;
  logic [7:0] hostRdata, memDqOut, memDqIn;
  logic [17:0] memAddr;

  always #(PER/2) clk = ~clk;

  asram_ctl i_asram_ctl (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostReady(hostReady),
    .hostRdata(hostRdata), .hostRvalid(hostRvalid), .memAddr(memAddr),
    .memCe1N(memCe1N), .memCe2(memCe2), .memOeN(memOeN), .memWeN(memWeN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  // ---------------- memory responder ----------------
  logic [7:0] respMem [int];
  function automatic logic [7:0] fill(input logic [17:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction
  always_comb
    if (!memCe1N && !memOeN && memWeN)
      memDqIn = respMem.exists(int'(memAddr)) ? respMem[int'(memAddr)] : fill(memAddr);
    else
      memDqIn = 8'h00;
  always @(negedge clk)
    if (!memCe1N && !memWeN && memDqOe) respMem[int'(memAddr)] = memDqOut;

  // ---------------- reference model ----------------
  typedef struct {
    bit ce1n, oen, wen, drive, ready, rvalid;
    logic [7:0] dq, rd;
    string tag;
  } exp_t;
  exp_t expQ[$];
  logic [7:0] shadow [int];
  logic [17:0] curAddr = '0;
  int checks = 0, errors = 0, oeHigh = 1000;
  bit prevDrive = 1'b0;

  function automatic exp_t mk(bit ce1n, bit oen, bit wen, bit drive, bit rvalid,
                              logic [7:0] dq, logic [7:0] rd, string tag);
    exp_t e;
    e.ce1n = ce1n; e.oen = oen; e.wen = wen; e.drive = drive; e.ready = 1'b0;
    e.rvalid = rvalid; e.dq = dq; e.rd = rd; e.tag = tag;
    return e;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      exp_t e;
      if (expQ.size() != 0) e = expQ.pop_front();
      else begin
        e = mk(1, 1, 1, 0, 0, 8'h00, 8'h00, "R1");
        e.ready = 1'b1;
      end
      chk(memCe1N == e.ce1n, e.tag, "memCe1N", memCe1N, e.ce1n);
      chk(memOeN == e.oen, e.tag, "memOeN", memOeN, e.oen);
      chk(memWeN == e.wen, e.tag, "memWeN", memWeN, e.wen);
      chk(memDqOe == e.drive, e.tag, "memDqOe", memDqOe, e.drive);
      chk(hostReady == e.ready, "R8", "hostReady", hostReady, e.ready);
      chk(hostRvalid == e.rvalid, "R3", "hostRvalid", hostRvalid, e.rvalid);
      chk(memCe2 == 1'b1, "R1", "memCe2", memCe2, 1);
      chk(memAddr == curAddr, "R6", "memAddr", memAddr, curAddr);
      chk(!(!memOeN && !memWeN), "R9", "oe/we overlap", {memOeN, memWeN}, 2'b11);
      if (e.drive) chk(memDqOut == e.dq, "R4", "memDqOut", memDqOut, e.dq);
      if (e.rvalid) chk(hostRdata == e.rd, "R3", "hostRdata", hostRdata, e.rd);
      if (memDqOe && !prevDrive) chk(oeHigh >= TURN, "R7", "turnaround cycles", oeHigh, TURN);
      prevDrive = memDqOe;
      oeHigh = memOeN ? oeHigh + 1 : 0;
      // request seen now will be accepted at the next rising edge
      if (hostReq && hostReady) begin
        if (!hostWrite) begin
          logic [7:0] rv;
          rv = shadow.exists(int'(hostAddr)) ? shadow[int'(hostAddr)] : fill(hostAddr);
          expQ.push_back(mk(1, 1, 1, 0, 0, 8'h00, 8'h00, "R2"));
          for (int i = 0; i < RD; i++) expQ.push_back(mk(0, 0, 1, 0, 0, 8'h00, 8'h00, "R2"));
          expQ.push_back(mk(1, 1, 1, 0, 1, 8'h00, rv, "R3"));
        end else begin
          for (int i = 0; i < TURN - (oeHigh); i++)
            expQ.push_back(mk(1, 1, 1, 0, 0, 8'h00, 8'h00, "R7"));
          expQ.push_back(mk(1, 1, 1, 1, 0, hostWdata, 8'h00, "R4"));
          for (int i = 0; i < WP; i++) expQ.push_back(mk(0, 1, 0, 1, 0, hostWdata, 8'h00, "R4"));
          for (int i = 0; i < REC; i++) expQ.push_back(mk(1, 1, 1, 1, 0, hostWdata, 8'h00, "R5"));
          shadow[int'(hostAddr)] = hostWdata;
        end
        curAddr = hostAddr;
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic access(bit wr, logic [17:0] a, logic [7:0] d);
    @(posedge clk); #2;
    while (!hostReady) begin @(posedge clk); #2; end
    hostReq = 1'b1; hostWrite = wr; hostAddr = a; hostWdata = d;
    @(posedge clk); #2;
    // R8: scramble host inputs during the access; pins must not follow
    hostReq = 1'b0; hostWrite = ~wr; hostAddr = ~a; hostWdata = ~d;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(hostReady && memCe1N && memOeN && memWeN && !memDqOe && memCe2, "R1", "reset pins",
        {hostReady, memCe1N, memOeN, memWeN, memDqOe}, 5'b11110);
    rstN = 1'b1;
    access(1, 18'h00012, 8'hA5);      // R4 R5 plain write
    access(0, 18'h00012, 8'h00);      // R2 R3 read back
    access(0, 18'h3FFFF, 8'h00);      // R3 unwritten top address
    access(1, 18'h3FFFF, 8'h3C);      // R7 write directly after a read
    access(1, 18'h00000, 8'hFF);      // back-to-back writes
    access(0, 18'h3FFFF, 8'h00);      // R8 data from before scramble
    access(0, 18'h00000, 8'h00);
    access(1, 18'h12345, 8'h00);
    access(0, 18'h12345, 8'h00);
    access(0, 18'h00012, 8'h00);
    repeat (12) @(posedge clk);
    chk(expQ.size() == 0, "R8", "model drained", expQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule